// File: doc/BRIEF.md
# Fixed-Length Burst Receive Checker

This block watches a 16-bit receive packet bus from the downstream side. Data arrives in bursts of consecutive valid words. A burst with no end-of-packet marker must carry exactly `(burst_code+1)*16` bytes. A burst that carries an end-of-packet word may stop sooner. A sender that quits a burst early leaves the bus undriven. The undriven bus shows up either as `valid` falling to 0 in the middle of a burst, because valid is pulled down, or as `err` reading 1 with no end-of-packet, because err is pulled up. Words are also checked against an odd parity bit.

Clean words are passed on one cycle later. When a fault is found, the block raises a one-cycle discard flag and does not forward the faulty word. It then drops every word up to and including the next end-of-packet word, and after that it checks normally again. The discard flag tells the consumer to throw away the part of the packet it has already received. The burst-size code must be held steady while a burst is in flight.

Top module: `burst_rx_chk`

## Requirements
- R1: While reset is held and right after it is released, `out_valid`, `out_eop`, `out_discard` and `out_data` are all 0.
- R2: A valid word that passes every check appears on `out_data` with `out_valid`=1 on the next cycle. A burst of exactly `(burst_code+1)*8` words with no end-of-packet raises no discard, and the word that follows it starts a new burst.
- R3: A word with `bus_eop`=1 ends the packet at any length without a discard. `out_eop` is 1 only together with `out_valid`.
- R4: If `bus_valid` is 0 while a burst is partly received (at least one word and fewer than the full count), `out_discard` is 1 on the next cycle. This is well within the 16-cycle detection limit.
- R5: A valid word with `bus_err`=1 and `bus_eop`=0 raises `out_discard` on the next cycle and is not forwarded.
- R6: Parity is odd. `{bus_data,bus_par}` must contain an odd number of ones. A valid word that breaks this raises `out_discard` on the next cycle and is not forwarded.
- R7: After a discard caused by a word without end-of-packet, no word is forwarded and no further discard is raised up to and including the next end-of-packet word. Normal checking resumes with the word after that.
- R8: With `burst_code`=0, a burst is 8 words (16 bytes), and back-to-back 8-word bursts separated by idle cycles raise no discard.
- R9: Idle cycles between bursts raise no discard, even when `bus_err` is 1 while `bus_valid` is 0.
- R10: `bus_err`=1 on an end-of-packet word is legal. The word is forwarded and no discard is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_code | input | 4 | Burst-size code; a full burst is (code+1)*16 bytes |
| bus_valid | input | 1 | Bus word valid (reads 0 when the bus floats) |
| bus_data | input | 16 | Bus data word |
| bus_par | input | 1 | Odd parity bit over bus_data |
| bus_eop | input | 1 | End-of-packet marker on this word |
| bus_err | input | 1 | Error line (reads 1 when the bus floats) |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | 16 | Forwarded word (0 when not valid) |
| out_eop | output | 1 | Forwarded word ends a packet |
| out_discard | output | 1 | One-cycle pulse: current packet must be discarded |

## Verification
The byte counter can drift, for example by stepping or wrapping at the wrong value. That fault does not show when a full burst completes. It shows on the first idle cycle that the counter wrongly treats as mid-burst, which produces a spurious `out_discard` one cycle later. It can also show as a missing discard when a burst really is cut short. A drop state that is stuck on or released too early shows within one word: clean words go missing on `out_valid`, or dropped words appear on it. Random packets with mixed code values, together with directed full-length, short and code-15 bursts, make these mismatches visible at the ports within one or two cycles.

// File: rtl/burst_rx_pkg.sv
package burst_rx_pkg;
  localparam int BRX_DATA_W     = 16;
  localparam int BRX_CODE_W     = 4;
  localparam int BRX_UNIT_BYTES = 16;

  // bytes in a full non-terminated burst for a given size code
  function automatic int burst_bytes(input int code, input int unit);
    return (code + 1) * unit;
  endfunction

  // bytes carried by one bus word
  function automatic int word_bytes(input int data_w);
    return data_w / 8;
  endfunction
endpackage

// File: rtl/brx_parity.sv
module brx_parity #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              ok
);
  // odd parity: total count of ones over data and parity bit is odd
  assign ok = ^{par, data};
endmodule

// File: rtl/brx_len_ctr.sv
module brx_len_ctr #(
  parameter int CODE_W     = 4,
  parameter int UNIT_BYTES = 16,
  parameter int WORD_B     = 2,
  parameter int CNT_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              adv,
  input  logic              clr,
  output logic              mid,
  output logic [CNT_W-1:0]  bytes
);
  import burst_rx_pkg::*;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] nxt;

  assign limit = CNT_W'(burst_bytes(int'(code), UNIT_BYTES));
  assign nxt   = bytes + CNT_W'(WORD_B);
  assign mid   = (bytes != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bytes <= '0;
    end else if (adv) begin
      bytes <= (nxt >= limit) ? '0 : nxt;
    end
  end
endmodule

// File: rtl/brx_drop_ctl.sv
module brx_drop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic eop_word,
  output logic dropping
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dropping <= 1'b0;
    end else if (dropping) begin
      if (eop_word) dropping <= 1'b0;
    end else if (set) begin
      dropping <= 1'b1;
    end
  end
endmodule

// File: rtl/burst_rx_chk.sv
module burst_rx_chk #(
  parameter int DATA_W     = burst_rx_pkg::BRX_DATA_W,
  parameter int CODE_W     = burst_rx_pkg::BRX_CODE_W,
  parameter int UNIT_BYTES = burst_rx_pkg::BRX_UNIT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] burst_code,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_par,
  input  logic              bus_eop,
  input  logic              bus_err,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eop,
  output logic              out_discard
);
  import burst_rx_pkg::*;

  localparam int WORD_B = word_bytes(DATA_W);
  localparam int CNT_W  = $clog2((2**CODE_W) * UNIT_BYTES + 1);

  // named internal events
  logic             par_ok;
  logic             mid_burst;
  logic             dropping;
  logic             trunc_idle;
  logic             trunc_float;
  logic             par_bad;
  logic             fault;
  logic             fwd;
  logic             eop_word;
  logic [CNT_W-1:0] byte_cnt;

  brx_parity #(.DATA_W(DATA_W)) u_par (
    .data (bus_data),
    .par  (bus_par),
    .ok   (par_ok)
  );

  assign eop_word    = bus_valid & bus_eop;
  assign trunc_idle  = ~bus_valid & mid_burst;
  assign trunc_float = bus_valid & bus_err & ~bus_eop;
  assign par_bad     = bus_valid & ~par_ok;
  assign fault       = ~dropping & (trunc_idle | trunc_float | par_bad);
  assign fwd         = bus_valid & ~dropping & ~fault;

  brx_len_ctr #(
    .CODE_W     (CODE_W),
    .UNIT_BYTES (UNIT_BYTES),
    .WORD_B     (WORD_B),
    .CNT_W      (CNT_W)
  ) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (burst_code),
    .adv   (fwd & ~bus_eop),
    .clr   (fault | dropping | eop_word),
    .mid   (mid_burst),
    .bytes (byte_cnt)
  );

  brx_drop_ctl u_drop (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (fault & ~eop_word),
    .eop_word (eop_word),
    .dropping (dropping)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_eop     <= 1'b0;
      out_discard <= 1'b0;
    end else begin
      out_valid   <= fwd;
      out_data    <= fwd ? bus_data : '0;
      out_eop     <= fwd & bus_eop;
      out_discard <= fault;
    end
  end
endmodule

// File: rtl/burst_rx_chk_sva.sv
module burst_rx_chk_sva #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_par,
  input logic              bus_eop,
  input logic              bus_err,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_eop,
  input logic              out_discard,
  input logic              mid_burst,
  input logic              dropping,
  input logic              fault
);
  assert_fwd_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !dropping && !fault) |=> (out_valid && out_data == $past(bus_data)));

  assert_eop_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);

  assert_idle_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && mid_burst && !dropping) |=> out_discard);

  assert_float_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err && !bus_eop && !dropping) |=> (out_discard && !out_valid));

  assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(^{bus_par, bus_data}) && !dropping) |=> out_discard);

  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |=> (!out_valid && !out_discard));
endmodule

bind burst_rx_chk burst_rx_chk_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/sim_burst_rx_chk.sv
module sim_burst_rx_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  burst_code = '0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_data = '0;
  logic        bus_par = 1'b0;
  logic        bus_eop = 1'b0;
  logic        bus_err = 1'b0;
  logic        out_valid, out_eop, out_discard;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  int          m_bytes = 0;
  bit          m_drop  = 1'b0;
  logic [18:0] exp_out = '0;
  string       exp_req = "R1";

  burst_rx_chk u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic bit good_par(input logic [15:0] d);
    return ~^d;
  endfunction

  function automatic bit odd_ok(input logic [15:0] d, input bit p);
    return ($countones({d, p}) % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // compare the previous cycle's expectation, then drive and predict
  task automatic step(input bit v, input logic [15:0] d, input bit p,
                      input bit e, input bit r, input string req);
    int  lim;
    bit  flt;
    @(negedge clk);
    chk(exp_req, {out_valid, out_eop, out_discard, out_data}, exp_out);
    bus_valid = v; bus_data = d; bus_par = p; bus_eop = e; bus_err = r;
    exp_req = req;
    exp_out = '0;
    lim = (int'(burst_code) + 1) * 16;
    if (m_drop) begin
      m_bytes = 0;
      if (v && e) m_drop = 1'b0;
    end else begin
      flt = (!v && m_bytes > 0) || (v && r && !e) || (v && !odd_ok(d, p));
      if (flt) begin
        exp_out[16] = 1'b1;
        m_bytes = 0;
        if (!(v && e)) m_drop = 1'b1;
      end else if (v) begin
        exp_out = {1'b1, e, 1'b0, d};
        if (e) m_bytes = 0;
        else begin
          m_bytes += 2;
          if (m_bytes >= lim) m_bytes = 0;
        end
      end
    end
  endtask

  task automatic idle(input int n, input bit r, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 1'b0, r, req);
  endtask

  // kind: 0 clean, 1 bad parity, 2 idle gap, 3 err without eop; at = word index
  task automatic send_pkt(input int code, input int nw, input int kind,
                          input int at, input bit eop_err, input string req);
    logic [15:0] d;
    int w;
    burst_code = code[3:0];
    w = (code + 1) * 8;
    for (int i = 0; i < nw; i++) begin
      d = 16'($urandom);
      if (kind == 2 && i == at && (i % w) != 0) idle(1, 1'b0, req);
      if (kind == 1 && i == at)
        step(1'b1, d, ~good_par(d), i == nw - 1, 1'b0, req);
      else if (kind == 3 && i == at && i != nw - 1)
        step(1'b1, d, good_par(d), 1'b0, 1'b1, req);
      else
        step(1'b1, d, good_par(d), i == nw - 1, (i == nw - 1) && eop_err, req);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5A17);
    repeat (3) begin
      @(negedge clk);
      chk("R1", {out_valid, out_eop, out_discard, out_data}, '0);
    end
    rst_n = 1'b1;

    // R2: full 24-word bursts at code 2, then terminated packet
    send_pkt(2, 24 * 2 + 5, 0, 0, 1'b0, "R2");
    idle(2, 1'b0, "R2");
    // R8: code 0, 8-word bursts with gaps
    burst_code = 4'd0;
    send_pkt(0, 8, 0, 0, 1'b0, "R8");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8; i++) step(1'b1, 16'(k * 16 + i), good_par(16'(k * 16 + i)), 1'b0, 1'b0, "R8");
      idle(1, 1'b0, "R8");
    end
    send_pkt(0, 3, 0, 0, 1'b0, "R8");
    // R3: short terminated packet
    send_pkt(3, 5, 0, 0, 1'b0, "R3");
    // R9: idle with err high between bursts
    idle(3, 1'b1, "R9");
    // R4 + R7: valid drop mid burst, rest of packet dropped, then clean packet
    send_pkt(1, 14, 2, 5, 1'b0, "R4");
    send_pkt(1, 4, 0, 0, 1'b0, "R7");
    // R5: err without eop
    send_pkt(2, 10, 3, 3, 1'b0, "R5");
    send_pkt(2, 2, 0, 0, 1'b0, "R7");
    // R6: bad parity mid packet and on eop word
    send_pkt(1, 9, 1, 4, 1'b0, "R6");
    send_pkt(1, 3, 1, 2, 1'b0, "R6");
    send_pkt(1, 3, 0, 0, 1'b0, "R6");
    // R10: err on eop word
    send_pkt(0, 4, 0, 0, 1'b1, "R10");
    // R2 at largest code: 128-word burst then short end
    send_pkt(15, 128 + 7, 0, 0, 1'b0, "R2");
    idle(1, 1'b0, "R2");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int code, nw, kind;
      code = int'($urandom % 4);
      nw   = 1 + int'($urandom % ((code + 1) * 16 + 3));
      kind = ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0;
      send_pkt(code, nw, kind, int'($urandom % nw), ($urandom % 5) == 0,
               kind == 1 ? "R6" : kind == 2 ? "R4" : kind == 3 ? "R5" : "R2");
      idle(int'($urandom % 3), ($urandom % 2) == 1, "R9");
    end
    idle(2, 1'b0, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule